// File: doc/BRIEF.md
# Multi-lane SPI bus monitor

The block listens passively to a serial peripheral bus. It takes in chip-select, the bus clock and up to four data lines, and rebuilds the bytes moved across the bus. It never drives any bus line. All bus inputs cross into the system clock through a two-flop synchroniser. The system clock must run at least four times faster than the bus clock.

Software-free configuration pins set three things: the clock polarity, the clock phase and the lane mode. The lane mode selects single, dual or quad data. From the polarity and phase the block picks which bus-clock transition captures data. At each capture it shifts the current lane bits into a partial byte, most significant bit first. Each finished byte appears on an 8-bit output together with a one-cycle valid strobe.

At the start of every transfer the block checks the idle level of the bus clock. If that level does not match the configured polarity, it raises a mismatch flag and suppresses all bytes from that transfer.

Top module: `spi_lane_monitor`

## Requirements
- R1: After synchronous reset, `byte_valid` and `cfg_mismatch` are 0.
- R2: While chip-select is high, no byte is emitted and bus clock toggles are ignored; nothing is captured before the first low chip-select.
- R3: If the synchronised bus clock level, in the first cycle chip-select is seen low, differs from `cfg_cpol`, then `cfg_mismatch` goes to 1. It stays at 1 until chip-select is seen high again or reset occurs. While it is 1, `byte_valid` stays 0.
- R4: When `cfg_cpol` equals `cfg_cphase`, data is captured on low-to-high bus clock transitions. Otherwise it is captured on high-to-low transitions. A capture requires the clock to have been seen at the opposite level first, within the current transfer.
- R5: With `cfg_lanes` = 2'b00 (single), each capture appends `bus_dq[0]`. Lines 3..1 are ignored. Eight captures form a byte, first bit in bit 7.
- R6: With `cfg_lanes` = 2'b01 (dual), each capture appends `bus_dq[1]` and then `bus_dq[0]`. Lines 3..2 are ignored. Four captures form a byte.
- R7: With `cfg_lanes` = 2'b10 or 2'b11 (quad), each capture appends `bus_dq[3]`, `bus_dq[2]`, `bus_dq[1]` and `bus_dq[0]` in that order. Two captures form a byte.
- R8: Each completed byte is shown on `byte_data` with `byte_valid` high for exactly one system clock. The next byte starts from an empty bit count.
- R9: When chip-select returns high, a partial byte is dropped without a strobe. The next transfer starts with an empty byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_cpol | input | 1 | Bus clock idle level |
| cfg_cphase | input | 1 | Clock phase select |
| cfg_lanes | input | 2 | Lane mode: 00 single, 01 dual, 1x quad |
| bus_csn | input | 1 | Bus chip-select, active low, asynchronous |
| bus_sck | input | 1 | Bus clock, asynchronous |
| bus_dq | input | 4 | Bus data lines, asynchronous |
| byte_data | output | 8 | Last reassembled byte |
| byte_valid | output | 1 | One-cycle strobe for a new byte |
| cfg_mismatch | output | 1 | Clock idle level did not match polarity |

## Verification
A bit counter that slips, or a wrong lane order, shows at the ports within the first byte of a transfer. The effect is a byte that is rotated or has its bit pairs swapped, or a strobe that is missing or extra. Sampling on the wrong edge is exposed because the bench drives junk on the data lines around the non-sampling edge. The error therefore appears in the very first capture. A stale count or a flag that does not clear after chip-select rises shows up in the next transfer, as a shifted or missing first byte.

// File: rtl/spi_lane_monitor.sv
module spi_lane_monitor #(
  parameter int BYTE_W = 8,
  parameter int DQ_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cphase,
  input  logic [1:0]        cfg_lanes,
  input  logic              bus_csn,
  input  logic              bus_sck,
  input  logic [DQ_W-1:0]   bus_dq,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_valid,
  output logic              cfg_mismatch
);
  localparam int CNT_W = $clog2(BYTE_W) + 1;

  logic [1:0]      csn_p, sck_p;
  logic [DQ_W-1:0] dq_a, dq_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csn_p <= 2'b11;
      sck_p <= 2'b00;
      dq_a  <= '0;
      dq_b  <= '0;
    end else begin
      csn_p <= {csn_p[0], bus_csn};
      sck_p <= {sck_p[0], bus_sck};
      dq_a  <= bus_dq;
      dq_b  <= dq_a;
    end
  end

  wire csn_s   = csn_p[1];
  wire sck_s   = sck_p[1];
  wire smp_lvl = (cfg_cpol == cfg_cphase);

  logic              active, armed;
  logic [CNT_W-1:0]  cnt, step, cnt_sum;
  logic [BYTE_W-1:0] sh, sh_nxt;

  always_comb begin
    case (cfg_lanes)
      2'b00:   begin step = CNT_W'(1); sh_nxt = {sh[BYTE_W-2:0], dq_b[0]}; end
      2'b01:   begin step = CNT_W'(2); sh_nxt = {sh[BYTE_W-3:0], dq_b[1], dq_b[0]}; end
      default: begin step = CNT_W'(4); sh_nxt = {sh[BYTE_W-5:0], dq_b[3:0]}; end
    endcase
  end

  assign cnt_sum = cnt + step;
  wire capture = active && !csn_s && armed && (sck_s == smp_lvl);
  wire done    = capture && (cnt_sum == CNT_W'(BYTE_W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active       <= 1'b0;
      armed        <= 1'b0;
      cfg_mismatch <= 1'b0;
      cnt          <= '0;
      sh           <= '0;
      byte_data    <= '0;
      byte_valid   <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (csn_s) begin
        active       <= 1'b0;
        armed        <= 1'b0;
        cfg_mismatch <= 1'b0;
        cnt          <= '0;
        sh           <= '0;
      end else if (!active) begin
        active       <= 1'b1;
        armed        <= 1'b0;
        cfg_mismatch <= (sck_s != cfg_cpol);
        cnt          <= '0;
        sh           <= '0;
      end else if (capture) begin
        armed <= 1'b0;
        sh    <= sh_nxt;
        if (done) begin
          cnt        <= '0;
          byte_data  <= sh_nxt;
          byte_valid <= !cfg_mismatch;
        end else begin
          cnt <= cnt_sum;
        end
      end else if (sck_s != smp_lvl) begin
        armed <= 1'b1;
      end
    end
  end

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !byte_valid);
  // R3
  mismatch_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mismatch |-> !byte_valid);
  // R3
  mismatch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !cfg_mismatch);
  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);
  // R9
  partial_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> (cnt == '0));
endmodule

// File: tb/spi_lane_monitor_tb.sv
module spi_lane_monitor_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_cpol = 1'b0, cfg_cphase = 1'b0;
  logic [1:0] cfg_lanes = 2'b00;
  logic       bus_csn = 1'b1, bus_sck = 1'b0;
  logic [3:0] bus_dq = 4'h0;
  logic [7:0] byte_data;
  logic       byte_valid, cfg_mismatch;

  always #2 clk = ~clk;

  spi_lane_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cphase(cfg_cphase),
    .cfg_lanes(cfg_lanes), .bus_csn(bus_csn), .bus_sck(bus_sck), .bus_dq(bus_dq),
    .byte_data(byte_data), .byte_valid(byte_valid), .cfg_mismatch(cfg_mismatch)
  );

  localparam int H = 3;
  int total = 0, bad = 0;
  int got_n = 0, wide = 0;
  logic [7:0] got [64];
  logic [7:0] exp_b [64];
  logic prev_v = 1'b0;
  bit done_flag = 1'b0;

  always @(negedge clk) begin
    if (byte_valid) begin
      if (got_n < 64) got[got_n] = byte_data;
      got_n++;
      if (prev_v) wide++;
    end
    prev_v = byte_valid;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [3:0] lane_val(input logic [1:0] ln, input logic [7:0] b,
                                          input int k, input logic [3:0] junk);
    case (ln)
      2'b00:   return {junk[3:1], b[7-k]};
      2'b01:   return {junk[3:2], b[7-2*k], b[6-2*k]};
      default: return (k == 0) ? b[7:4] : b[3:0];
    endcase
  endfunction

  function automatic int caps_per(input logic [1:0] ln);
    return (ln == 2'b00) ? 8 : (ln == 2'b01) ? 4 : 2;
  endfunction

  // one capture: good data around the sampling edge, junk around the other
  task automatic cap(input logic [3:0] v);
    logic [3:0] j;
    j = v ^ 4'($urandom_range(1, 15));
    bus_dq = cfg_cphase ? j : v;
    tick(H); bus_sck = ~bus_sck; tick(H);
    bus_dq = cfg_cphase ? v : j;
    tick(H); bus_sck = ~bus_sck; tick(H);
  endtask

  task automatic xfer(input bit pol, input bit pha, input logic [1:0] ln, input int nb,
                      input int extra, input bit wrong_idle, input string req);
    int cp;
    cfg_cpol = pol; cfg_cphase = pha; cfg_lanes = ln;
    bus_sck = wrong_idle ? ~pol : pol;
    tick(8);
    for (int i = 0; i < nb; i++) exp_b[i] = 8'($urandom);
    got_n = 0; wide = 0;
    bus_csn = 1'b0;
    tick(2 * H);
    chk(cfg_mismatch == wrong_idle, "R3 flag at select", cfg_mismatch, wrong_idle);
    if (wrong_idle) begin bus_sck = pol; tick(H); end
    cp = caps_per(ln);
    for (int i = 0; i < nb; i++)
      for (int k = 0; k < cp; k++) cap(lane_val(ln, exp_b[i], k, 4'($urandom)));
    for (int e = 0; e < extra; e++) cap(4'($urandom));
    tick(H);
    chk(cfg_mismatch == wrong_idle, "R3 flag held", cfg_mismatch, wrong_idle);
    bus_csn = 1'b1;
    tick(8);
    chk(cfg_mismatch == 1'b0, "R3 flag cleared", cfg_mismatch, 0);
    chk(got_n == (wrong_idle ? 0 : nb), req, got_n, wrong_idle ? 0 : nb);
    if (!wrong_idle)
      for (int i = 0; i < nb && i < got_n; i++)
        chk(got[i] == exp_b[i], req, got[i], exp_b[i]);
    chk(wide == 0, "R8 one-cycle strobe", wide, 0);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    tick(4);
    chk(byte_valid == 1'b0, "R1 valid after reset", byte_valid, 0);
    chk(cfg_mismatch == 1'b0, "R1 mismatch after reset", cfg_mismatch, 0);
    rst_n = 1'b1;
    tick(4);

    // R2: clock and data activity with chip-select high
    got_n = 0;
    for (int i = 0; i < 20; i++) cap(4'($urandom));
    tick(8);
    chk(got_n == 0, "R2 no capture while deselected", got_n, 0);
    chk(cfg_mismatch == 1'b0, "R2 no flag while deselected", cfg_mismatch, 0);

    // R4 with R5 R6 R7: all clock modes and lane modes
    for (int m = 0; m < 4; m++) begin
      xfer(m[1], m[0], 2'b00, 3, 0, 0, "R4 R5 single byte");
      xfer(m[1], m[0], 2'b01, 3, 0, 0, "R4 R6 dual byte");
      xfer(m[1], m[0], 2'b10, 3, 0, 0, "R4 R7 quad byte");
    end
    xfer(1'b0, 1'b1, 2'b11, 4, 0, 0, "R7 quad via code 11");

    // R9: partial bytes dropped, next transfer clean
    xfer(1'b0, 1'b0, 2'b01, 2, 3, 0, "R9 partial dropped");
    xfer(1'b1, 1'b0, 2'b00, 2, 7, 0, "R9 partial dropped single");
    xfer(1'b1, 1'b1, 2'b10, 1, 1, 0, "R9 partial dropped quad");
    xfer(1'b0, 1'b0, 2'b00, 2, 0, 0, "R9 fresh after partial");

    // R3: wrong idle level, both polarities
    xfer(1'b0, 1'b0, 2'b10, 2, 0, 1, "R3 bytes muted");
    xfer(1'b1, 1'b0, 2'b00, 1, 0, 1, "R3 bytes muted");
    xfer(1'b1, 1'b0, 2'b01, 2, 0, 0, "R3 recovers after clear");

    // random mix
    for (int r = 0; r < 16; r++)
      xfer(1'($urandom), 1'($urandom), 2'($urandom), $urandom_range(1, 4),
           $urandom_range(0, 1), 0, "R8 random transfer");

    done_flag = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule